// File: doc/BRIEF.md
# Supply and Watchdog Reset Controller

This block produces the processor reset. It keeps reset asserted while a synchronous supply-good flag from an external comparator is low. It releases reset only after that flag has stayed high for a fixed number of timebase ticks without a break. A millisecond tick input provides the timebase. All durations are counted in ticks, so a different tick rate or different tick counts only change parameters.

Once reset is released, a watchdog counts ticks. Software must keep producing falling edges on a kick input. The kick input is synchronized, then filtered so that a level shorter than a minimum width is ignored. A two-bit select picks one of three timeout lengths or switches the watchdog off. If the timeout expires with no qualified falling edge, reset is asserted for a fixed hold time and then released. A sticky cause output tells software whether the most recent reset came from the watchdog or from the supply. The output polarity is chosen by a parameter.

Top module: `sup_rst_wdog`

## Requirements
- R1: While `supply_ok_i` is low, the internal reset state is set on the next clock edge and `cause_wdog_o` reads 0.
- R2: Reset releases on the tick that completes `STABLE_TICKS` ticks (default 200) with `supply_ok_i` held high. Any low cycle restarts that count from zero.
- R3: After `rst_n` is deasserted, reset is active with `cause_wdog_o` = 0. The first release needs the full supply-stable interval.
- R4: The timeout codes on `period_sel_i` are: 2'b00 selects `PERIOD_LONG` ticks (1400), 2'b01 selects `PERIOD_MID` ticks (600), and 2'b10 selects `PERIOD_SHORT` ticks (200). When that many ticks pass with no qualified kick edge, reset is asserted.
- R5: Code 2'b11 disables the watchdog, so reset stays released for as long as the supply is good.
- R6: A qualified falling edge on `kick_i` restarts the timeout count from zero.
- R7: After the two-flop synchronizer, a new `kick_i` level counts only once it has held for `KICK_MIN_CYC` consecutive clocks (default 50, 400 ns at 125 MHz). Shorter pulses have no effect.
- R8: A watchdog reset lasts `WD_HOLD_TICKS` ticks (200) and then releases by itself.
- R9: A supply drop has priority over a watchdog expiry in the same cycle. A drop during a watchdog reset restarts the full supply-stable interval and sets the cause to supply.
- R10: The watchdog count is held at zero while reset is active. It starts from zero when reset releases.
- R11: `cause_wdog_o` becomes 1 when a watchdog expiry asserts reset and 0 when the supply drops. It keeps its value until the next reset event.
- R12: With `ACTIVE_HIGH` = 1, `reset_o` is 1 while reset is active. With `ACTIVE_HIGH` = 0 it is the complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | One-cycle timebase strobe (nominally every 1 ms) |
| supply_ok_i | input | 1 | Synchronous supply-good flag from the comparator |
| kick_i | input | 1 | Asynchronous watchdog kick; falling edges restart the timeout |
| period_sel_i | input | 2 | Watchdog timeout select; 2'b11 disables |
| reset_o | output | 1 | Processor reset, polarity set by `ACTIVE_HIGH` |
| cause_wdog_o | output | 1 | 1 if the last reset came from the watchdog, 0 if from the supply |

## Verification
A watchdog expiry and a supply drop can arrive in the same clock cycle, and the supply must win. The bench runs its behavioural model alongside the design. When the model shows that the timeout will expire at the next edge, the bench pulls `supply_ok_i` low in that same cycle. It then expects reset to be active with `cause_wdog_o` at 0, and expects the release to wait for a full supply-stable interval rather than the watchdog hold time. Every cycle, the reset and cause outputs of both polarity variants are compared with the model.

// File: rtl/srw_pkg.sv
package srw_pkg;
  typedef enum logic {
    CAUSE_SUPPLY = 1'b0,
    CAUSE_WDOG   = 1'b1
  } cause_e;

  localparam logic [1:0] SEL_LONG  = 2'b00;
  localparam logic [1:0] SEL_MID   = 2'b01;
  localparam logic [1:0] SEL_SHORT = 2'b10;
  localparam logic [1:0] SEL_OFF   = 2'b11;
endpackage

// File: rtl/srw_kick_cond.sv
module srw_kick_cond #(
  parameter int unsigned MIN_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic fall_o
);
  localparam int unsigned CW = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic [1:0]    sync_q;
  logic          filt_q, filt_d;
  logic [CW-1:0] run_q, run_d;
  logic          differ, done;

  always_comb begin
    differ = sync_q[1] ^ filt_q;
    done   = differ && (run_q == LAST);
    run_d  = (!differ || done) ? '0 : run_q + 1'b1;
    filt_d = done ? sync_q[1] : filt_q;
    fall_o = done && !sync_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
      filt_q <= 1'b0;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], kick_i};
      filt_q <= filt_d;
      run_q  <= run_d;
    end
  end

  // R7: a qualified falling edge needs the synchronized level already low in the previous cycle
  p_fall_needs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> $past(sync_q[1] == 1'b0));
endmodule

// File: rtl/srw_wdog_timer.sv
module srw_wdog_timer
  import srw_pkg::*;
#(
  parameter int unsigned PERIOD_LONG  = 1400,
  parameter int unsigned PERIOD_MID   = 600,
  parameter int unsigned PERIOD_SHORT = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       hold_i,
  input  logic       kick_fall_i,
  input  logic [1:0] sel_i,
  output logic       expire_o
);
  localparam int unsigned MAXLM = (PERIOD_LONG > PERIOD_MID) ? PERIOD_LONG : PERIOD_MID;
  localparam int unsigned MAXP  = (MAXLM > PERIOD_SHORT) ? MAXLM : PERIOD_SHORT;
  localparam int unsigned CW    = $clog2(MAXP + 1);
  localparam logic [CW-1:0] LAST_LONG  = CW'(PERIOD_LONG - 1);
  localparam logic [CW-1:0] LAST_MID   = CW'(PERIOD_MID - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(PERIOD_SHORT - 1);

  logic [CW-1:0] cnt_q, cnt_d, last;
  logic          run;

  always_comb begin
    case (sel_i)
      SEL_LONG:  last = LAST_LONG;
      SEL_MID:   last = LAST_MID;
      SEL_SHORT: last = LAST_SHORT;
      default:   last = '0;
    endcase
    run      = !hold_i && (sel_i != SEL_OFF);
    expire_o = run && tick_i && !kick_fall_i && (cnt_q >= last);
    if (!run || kick_fall_i || expire_o) cnt_d = '0;
    else if (tick_i)                     cnt_d = cnt_q + 1'b1;
    else                                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10: the count is held at zero while reset is active
  p_hold_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == '0));
  // R5: the disable code keeps the counter idle
  p_off_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == SEL_OFF) |=> (cnt_q == '0));
  // R4: the count never passes the longest period
  p_cnt_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < MAXP);
endmodule

// File: rtl/srw_reset_seq.sv
module srw_reset_seq
  import srw_pkg::*;
#(
  parameter int unsigned STABLE_TICKS  = 200,
  parameter int unsigned WD_HOLD_TICKS = 200
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick_i,
  input  logic   supply_ok_i,
  input  logic   expire_i,
  output logic   in_reset_o,
  output cause_e cause_o
);
  localparam int unsigned MAXH = (STABLE_TICKS > WD_HOLD_TICKS) ? STABLE_TICKS : WD_HOLD_TICKS;
  localparam int unsigned HW   = $clog2(MAXH + 1);
  localparam logic [HW-1:0] LAST_STABLE = HW'(STABLE_TICKS - 1);
  localparam logic [HW-1:0] LAST_WD     = HW'(WD_HOLD_TICKS - 1);

  logic          in_reset_q, in_reset_d;
  logic [HW-1:0] hold_q, hold_d, hold_last;
  cause_e        cause_q, cause_d;

  always_comb begin
    hold_last  = (cause_q == CAUSE_WDOG) ? LAST_WD : LAST_STABLE;
    in_reset_d = in_reset_q;
    hold_d     = hold_q;
    cause_d    = cause_q;
    if (!supply_ok_i) begin
      in_reset_d = 1'b1;
      hold_d     = '0;
      cause_d    = CAUSE_SUPPLY;
    end else if (in_reset_q) begin
      if (tick_i) begin
        if (hold_q >= hold_last) begin
          in_reset_d = 1'b0;
          hold_d     = '0;
        end else begin
          hold_d = hold_q + 1'b1;
        end
      end
    end else if (expire_i) begin
      in_reset_d = 1'b1;
      hold_d     = '0;
      cause_d    = CAUSE_WDOG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_reset_q <= 1'b1;
      hold_q     <= '0;
      cause_q    <= CAUSE_SUPPLY;
    end else begin
      in_reset_q <= in_reset_d;
      hold_q     <= hold_d;
      cause_q    <= cause_d;
    end
  end

  assign in_reset_o = in_reset_q;
  assign cause_o    = cause_q;

  // R1: a low supply flag forces reset with supply cause
  p_supply_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> (in_reset_q && cause_q == CAUSE_SUPPLY));
  // R2: release only happens on a tick with the supply good
  p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_reset_q) |-> $past(tick_i && supply_ok_i));
  // R8: an expiry with good supply enters reset
  p_expire_enters_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && supply_ok_i) |=> in_reset_q);
  // R11: the watchdog cause only appears after an expiry
  p_wdog_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_q == CAUSE_WDOG) |-> $past(expire_i));
endmodule

// File: rtl/sup_rst_wdog.sv
module sup_rst_wdog
  import srw_pkg::*;
#(
  parameter bit          ACTIVE_HIGH   = 1'b1,
  parameter int unsigned KICK_MIN_CYC  = 50,
  parameter int unsigned STABLE_TICKS  = 200,
  parameter int unsigned WD_HOLD_TICKS = 200,
  parameter int unsigned PERIOD_LONG   = 1400,
  parameter int unsigned PERIOD_MID    = 600,
  parameter int unsigned PERIOD_SHORT  = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       supply_ok_i,
  input  logic       kick_i,
  input  logic [1:0] period_sel_i,
  output logic       reset_o,
  output logic       cause_wdog_o
);
  logic   kick_fall;
  logic   expire;
  logic   in_reset;
  cause_e cause;

  srw_kick_cond #(.MIN_CYC(KICK_MIN_CYC)) u_kick (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick_i (kick_i),
    .fall_o (kick_fall)
  );

  srw_wdog_timer #(
    .PERIOD_LONG  (PERIOD_LONG),
    .PERIOD_MID   (PERIOD_MID),
    .PERIOD_SHORT (PERIOD_SHORT)
  ) u_wdog (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .hold_i      (in_reset),
    .kick_fall_i (kick_fall),
    .sel_i       (period_sel_i),
    .expire_o    (expire)
  );

  srw_reset_seq #(
    .STABLE_TICKS  (STABLE_TICKS),
    .WD_HOLD_TICKS (WD_HOLD_TICKS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .supply_ok_i (supply_ok_i),
    .expire_i    (expire),
    .in_reset_o  (in_reset),
    .cause_o     (cause)
  );

  generate
    if (ACTIVE_HIGH) begin : g_pol_hi
      assign reset_o = in_reset;
    end else begin : g_pol_lo
      assign reset_o = ~in_reset;
    end
  endgenerate

  assign cause_wdog_o = (cause == CAUSE_WDOG);
endmodule

// File: tb/test_sup_rst_wdog.sv
module test_sup_rst_wdog;
  localparam int K = 50, STB = 200, WDH = 200, PL = 1400, PM = 600, PS = 200, TDIV = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, tick, supply_ok, kick;
  logic [1:0] sel;
  logic       reset_hi, cause_hi, reset_lo, cause_lo;

  sup_rst_wdog #(.ACTIVE_HIGH(1'b1)) i_sup_rst_wdog (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .supply_ok_i(supply_ok), .kick_i(kick),
    .period_sel_i(sel), .reset_o(reset_hi), .cause_wdog_o(cause_hi));

  sup_rst_wdog #(.ACTIVE_HIGH(1'b0)) i_sup_rst_wdog_lo (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .supply_ok_i(supply_ok), .kick_i(kick),
    .period_sel_i(sel), .reset_o(reset_lo), .cause_wdog_o(cause_lo));

  int    checks = 0, fails = 0, tdc = 0;
  string phase = "R3 power-up";
  bit    done = 1'b0;

  // behavioural reference model
  bit m_s1, m_s2, m_f, m_inrst, m_cause;
  int m_run, m_wd, m_hold;
  always @(posedge clk or negedge rst_n) begin : model
    bit differ, fall, run, expire;
    int lim, hl;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_f = 0; m_run = 0; m_wd = 0; m_hold = 0;
      m_inrst = 1; m_cause = 0;
    end else begin
      differ = (m_s2 != m_f);
      fall   = differ && (m_run == K - 1) && !m_s2;
      if (!differ) m_run = 0;
      else if (m_run == K - 1) begin m_run = 0; m_f = m_s2; end
      else m_run++;
      m_s2 = m_s1; m_s1 = kick;
      lim    = (sel == 2'b00) ? PL : (sel == 2'b01) ? PM : PS;
      run    = !m_inrst && (sel != 2'b11);
      expire = run && tick && !fall && (m_wd >= lim - 1);
      if (!run || fall || expire) m_wd = 0;
      else if (tick) m_wd++;
      hl = m_cause ? WDH : STB;
      if (!supply_ok) begin m_inrst = 1; m_hold = 0; m_cause = 0; end
      else if (m_inrst) begin
        if (tick) begin
          if (m_hold >= hl - 1) begin m_inrst = 0; m_hold = 0; end
          else m_hold++;
        end
      end else if (expire) begin m_inrst = 1; m_hold = 0; m_cause = 1; end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // per-cycle comparison; R12 polarity check on the second instance
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(reset_hi === m_inrst, {phase, " reset_o"}, reset_hi, m_inrst);
      check(cause_hi === m_cause, {phase, " cause_wdog_o (R11)"}, cause_hi, m_cause);
      check(reset_lo === !m_inrst, "R12 low-polarity reset_o", reset_lo, !m_inrst);
      check(cause_lo === m_cause, "R12 low-polarity cause", cause_lo, m_cause);
    end
  end

  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tdc  = (tdc + 1) % TDIV;
      tick = (tdc == 0);
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic kick_low(input int cyc);
    kick = 1'b0;
    repeat (cyc) @(negedge clk);
    kick = 1'b1;
  endtask

  task automatic wait_level(input bit lvl, input int maxc, output int n);
    n = 0;
    while (reset_hi !== lvl && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic expect_out(input string tag, input bit er, input bit ec);
    check(reset_hi === er, {tag, " reset_o"}, reset_hi, er);
    check(cause_hi === ec, {tag, " cause_wdog_o"}, cause_hi, ec);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; supply_ok = 1'b0; kick = 1'b1; sel = 2'b11;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R3 reset state", 1'b1, 1'b0);
    wait_ticks(10);
    expect_out("R1 supply low", 1'b1, 1'b0);

    supply_ok = 1'b1;
    wait_ticks(100);
    expect_out("R3 first release waits", 1'b1, 1'b0);

    phase = "R2 interruption";
    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    wait_ticks(150);
    expect_out("R2 count restarted", 1'b1, 1'b0);
    wait_ticks(60);
    expect_out("R2 released", 1'b0, 1'b0);

    phase = "R5 disabled";
    wait_ticks(1600);
    expect_out("R5 no expiry when off", 1'b0, 1'b0);

    phase = "R6 kicks";
    sel = 2'b10;
    repeat (8) begin
      kick_low(60);
      wait_ticks(150);
    end
    expect_out("R6 kicks hold off reset", 1'b0, 1'b0);

    phase = "R7 glitches";
    kick_low(60);
    repeat (6) begin
      kick_low(20);
      wait_ticks(40);
    end
    expect_out("R7 short pulses ignored, R4 expiry", 1'b1, 1'b1);

    phase = "R8 watchdog hold";
    wait_level(1'b0, WDH * TDIV, n);
    check(reset_hi === 1'b0, "R8 watchdog reset released", reset_hi, 0);
    check(cause_hi === 1'b1, "R11 cause sticky after release", cause_hi, 1);

    phase = "R10 restart from zero";
    wait_level(1'b1, (PS + 4) * TDIV, n);
    check(n >= (PS - 1) * TDIV && n <= (PS + 1) * TDIV, "R10 R4 short period from release", n, PS * TDIV);

    phase = "R9 drop during watchdog reset";
    wait_ticks(50);
    supply_ok = 1'b0;
    repeat (5) @(negedge clk);
    expect_out("R9 cause becomes supply", 1'b1, 1'b0);
    supply_ok = 1'b1;
    sel = 2'b01;
    wait_level(1'b0, (STB + 4) * TDIV, n);
    check(n >= (STB - 1) * TDIV, "R9 full stable interval restarted", n, STB * TDIV);

    phase = "R4 period 01";
    wait_level(1'b1, (PM + 4) * TDIV, n);
    check(n >= (PM - 1) * TDIV && n <= (PM + 1) * TDIV, "R4 mid period", n, PM * TDIV);
    sel = 2'b00;
    wait_level(1'b0, (WDH + 4) * TDIV, n);

    phase = "R4 period 00 with same-cycle drop";
    n = 0;
    forever begin
      @(negedge clk);
      #1;
      n++;
      if (tick && !m_inrst && m_wd >= PL - 1) break;
      if (n > (PL + 4) * TDIV) break;
    end
    check(n >= (PL - 1) * TDIV && n <= (PL + 1) * TDIV, "R4 long period", n, PL * TDIV);
    supply_ok = 1'b0;
    @(negedge clk);
    expect_out("R9 supply wins over expiry", 1'b1, 1'b0);
    supply_ok = 1'b1;
    wait_ticks(STB + 2);
    expect_out("R2 release after same-cycle drop", 1'b0, 1'b0);

    finish_run();
  end
endmodule